// File: doc/BRIEF.md
# Strobed Serial Channel Port

This block is the serial side of a four-channel voice transcoder. It connects one compressed-word stream and two PCM streams to a processing core. An external bit clock times the streams, and two enable strobes frame them. The strobes open two windows in each frame, one after the other. While a window is open, the port samples one bit from each input stream on every falling bit-clock edge and drives one bit on each output stream after every rising edge. When no window is open, every output is released to high-impedance, and the bit clock may stop entirely.

Each PCM stream carries either an 8-bit companded octet or a 16-bit linear word per window. The compressed stream packs its words according to the selected rate:
- two 4-bit words per window;
- two 3-bit words, each in a 4-bit slot;
- four 2-bit words in a single octet, placed in the window chosen by a select input.

The rising edge of the first strobe marks the frame boundary. At that edge the port hands the bits gathered in the previous frame to the core as parallel words. In the same cycle it loads the core's result words, which it then shifts out during the new frame. The bit clock is oversampled in the system clock domain. High-impedance is modelled by an output-enable per stream.

Top module: `ssi_port`

## Requirements
- R1: An input bit is taken at the falling bit-clock edge, so data changed after that edge and before the next rising edge is never captured. An output bit changes only after a rising edge and holds from that falling edge until the next rising edge.
- R2: Companded octets travel MSB first and occupy bits 7:0 of the 16-bit channel word. In window one, PCM stream 1 carries channel 0 and PCM stream 2 carries channel 2. In window two, they carry channels 1 and 3. Channel n sits at bits 16n+15:16n of the parallel PCM buses.
- R3: In linear mode, each PCM channel is a 16-bit word sent MSB first and passed through unchanged in both directions.
- R4: At rate code 0 (32 kb/s), the compressed stream carries channel 0 then channel 1 as 4-bit words, MSB first, in window one, and channels 2 and 3 in window two. Channel n sits at bits 4n+3:4n of the parallel compressed buses, with the first bit at position 3.
- R5: At rate code 1 (24 kb/s), the last bit of each 4-bit slot is ignored on input, where it is delivered as 0, and is driven as 0 on output.
- R6: At rate codes 2 and 3 (16 kb/s), one octet carries channels 0 to 3 in that order, two bits each. The octet travels in window one when the select input is 0 and in window two when it is 1. The compressed output is high-impedance in the other window. A received pair lands in bits 3:2 of its channel word and bits 1:0 read 0; on output, bits 3:2 are sent.
- R7: No output-enable is high while both strobes are low, and each data output is 0 while its enable is low. The compressed stream drives only the first 8 bit positions of a window. A PCM stream drives 8 positions, or 16 in linear mode.
- R8: A rising edge of strobe one transfers the bits captured since the previous such edge to the parallel outputs and pulses the frame flag for one cycle. The parallel outputs change at no other time. Channels that were not written during the frame read zero.
- R9: The result words are sampled only at the rising edge of strobe one. Later changes to them do not affect the bits shifted out in that frame.
- R10: After reset, all parallel outputs, the frame flag, all enables and all serial outputs are 0.
- R11: Bit-clock edges outside the windows, and a stopped bit clock between windows, do not disturb the captured data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_i | input | 1 | External bit clock |
| win1_i | input | 1 | Strobe for window one; its rising edge starts a frame |
| win2_i | input | 1 | Strobe for window two |
| rate_i | input | 2 | Compressed rate: 0 = 4-bit, 1 = 3-bit, 2 or 3 = 2-bit packed |
| lin_i | input | 1 | 1 selects 16-bit linear PCM |
| sel_i | input | 1 | Selects the window that carries the packed 2-bit octet |
| adp_rx_i | input | 1 | Compressed serial input |
| pcm1_rx_i | input | 1 | PCM stream 1 serial input |
| pcm2_rx_i | input | 1 | PCM stream 2 serial input |
| pcm_res_i | input | 64 | Core result PCM words, 16 bits per channel |
| adp_res_i | input | 16 | Core result compressed words, 4 bits per channel |
| adp_tx_o | output | 1 | Compressed serial output |
| adp_oe_o | output | 1 | Drive enable for adp_tx_o |
| pcm1_tx_o | output | 1 | PCM stream 1 serial output |
| pcm1_oe_o | output | 1 | Drive enable for pcm1_tx_o |
| pcm2_tx_o | output | 1 | PCM stream 2 serial output |
| pcm2_oe_o | output | 1 | Drive enable for pcm2_tx_o |
| rx_pcm_o | output | 64 | Received PCM words of the previous frame |
| rx_adp_o | output | 16 | Received compressed words of the previous frame |
| frame_o | output | 1 | One-cycle pulse after the parallel outputs update |

## Verification
At the frame boundary, two things happen in one cycle: the previous frame's capture moves to the parallel outputs, and the core's result words are loaded for transmission. The bench provokes both. It changes the result words between the two windows of a frame and checks that window two still carries the words present at the boundary. It then opens a frame with no bit-clock edges and checks that every channel reads zero, which shows the capture was cleared in the same cycle it was handed over. A further check changes the input data between each falling edge and the next rising edge, and counts any movement of the output bits over that interval.

// File: rtl/ssi_pkg.sv
package ssi_pkg;
    localparam int NCH   = 4;
    localparam int LIN_W = 16;
    localparam int OCT_W = 8;
    localparam int NIB_W = 4;
    localparam int CH_W  = $clog2(NCH);
    localparam int BIT_W = $clog2(LIN_W);
    localparam int NB_W  = $clog2(NIB_W);
    localparam int POS_W = $clog2(LIN_W) + 1;

    typedef struct packed {
        logic [CH_W-1:0]  pcm1_ch;
        logic [CH_W-1:0]  pcm2_ch;
        logic [BIT_W-1:0] pcm_bit;
        logic             pcm_ok;
        logic [CH_W-1:0]  adp_ch;
        logic [NB_W-1:0]  adp_bit;
        logic             adp_ok;
        logic             adp_dc;
    } slot_t;

    typedef struct packed {
        logic [POS_W-1:0]               pos;
        logic [POS_W-1:0]               opos;
        logic [NCH-1:0][LIN_W-1:0]      cap_pcm;
        logic [NCH-1:0][LIN_W-1:0]      hold_pcm;
        logic [NCH-1:0][LIN_W-1:0]      tx_pcm;
        logic [NCH-1:0][NIB_W-1:0]      cap_adp;
        logic [NCH-1:0][NIB_W-1:0]      hold_adp;
        logic [NCH-1:0][NIB_W-1:0]      tx_adp;
        logic                           frame;
    } port_st_t;
endpackage

// File: rtl/ssi_edge.sv
module ssi_edge #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl_i,
    output logic [N-1:0] rise_o,
    output logic [N-1:0] fall_o
);
    logic [N-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl_i;
    end

    for (genvar g = 0; g < N; g++) begin : g_edge
        assign rise_o[g] = lvl_i[g] & ~prev_q[g];
        assign fall_o[g] = ~lvl_i[g] & prev_q[g];
    end
endmodule

// File: rtl/ssi_slot_map.sv
module ssi_slot_map
    import ssi_pkg::*;
(
    input  logic [POS_W-1:0] pos_i,
    input  logic             win2_i,
    input  logic             lin_i,
    input  logic             sel_i,
    input  logic [1:0]       rate_i,
    output slot_t            slot_o
);
    logic [POS_W-1:0] lim;
    logic [2:0]       p3;
    logic             narrow;

    always_comb begin
        lim    = lin_i ? POS_W'(LIN_W) : POS_W'(OCT_W);
        p3     = pos_i[2:0];
        narrow = rate_i[1];

        slot_o.pcm_ok  = pos_i < lim;
        slot_o.pcm_bit = BIT_W'(lim - pos_i - POS_W'(1));
        slot_o.pcm1_ch = CH_W'(win2_i);
        slot_o.pcm2_ch = CH_W'(NCH / 2) + CH_W'(win2_i);

        slot_o.adp_ok = (pos_i < POS_W'(OCT_W)) && (!narrow || (win2_i == sel_i));
        if (narrow) begin
            slot_o.adp_ch  = p3[2:1];
            slot_o.adp_bit = {1'b1, ~p3[0]};
            slot_o.adp_dc  = 1'b0;
        end else begin
            slot_o.adp_ch  = {win2_i, p3[2]};
            slot_o.adp_bit = ~p3[1:0];
            slot_o.adp_dc  = rate_i[0] && (p3[1:0] == 2'b11);
        end
    end
endmodule

// File: rtl/ssi_port.sv
module ssi_port
    import ssi_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bclk_i,
    input  logic                   win1_i,
    input  logic                   win2_i,
    input  logic [1:0]             rate_i,
    input  logic                   lin_i,
    input  logic                   sel_i,
    input  logic                   adp_rx_i,
    input  logic                   pcm1_rx_i,
    input  logic                   pcm2_rx_i,
    input  logic [NCH*LIN_W-1:0]   pcm_res_i,
    input  logic [NCH*NIB_W-1:0]   adp_res_i,
    output logic                   adp_tx_o,
    output logic                   adp_oe_o,
    output logic                   pcm1_tx_o,
    output logic                   pcm1_oe_o,
    output logic                   pcm2_tx_o,
    output logic                   pcm2_oe_o,
    output logic [NCH*LIN_W-1:0]   rx_pcm_o,
    output logic [NCH*NIB_W-1:0]   rx_adp_o,
    output logic                   frame_o
);
    port_st_t   st_d, st_q;
    logic [2:0] rise, fall;
    logic       win_act, win2_sel;
    slot_t      mi, mo;

    ssi_edge #(.N(3)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  ({win2_i, win1_i, bclk_i}),
        .rise_o (rise),
        .fall_o (fall)
    );

    assign win_act  = win1_i | win2_i;
    assign win2_sel = win2_i & ~win1_i;

    ssi_slot_map u_map_in (
        .pos_i  (st_q.pos),
        .win2_i (win2_sel),
        .lin_i  (lin_i),
        .sel_i  (sel_i),
        .rate_i (rate_i),
        .slot_o (mi)
    );

    ssi_slot_map u_map_out (
        .pos_i  (st_q.opos),
        .win2_i (win2_sel),
        .lin_i  (lin_i),
        .sel_i  (sel_i),
        .rate_i (rate_i),
        .slot_o (mo)
    );

    always_comb begin
        st_d       = st_q;
        st_d.frame = 1'b0;
        if (rise[1]) begin
            st_d.hold_pcm = st_q.cap_pcm;
            st_d.hold_adp = st_q.cap_adp;
            st_d.cap_pcm  = '0;
            st_d.cap_adp  = '0;
            st_d.tx_pcm   = pcm_res_i;
            st_d.tx_adp   = adp_res_i;
            st_d.pos      = '0;
            st_d.opos     = '0;
            st_d.frame    = 1'b1;
        end else if (rise[2]) begin
            st_d.pos  = '0;
            st_d.opos = '0;
        end else if (win_act) begin
            if (fall[0]) begin
                if (mi.pcm_ok) begin
                    st_d.cap_pcm[mi.pcm1_ch][mi.pcm_bit] = pcm1_rx_i;
                    st_d.cap_pcm[mi.pcm2_ch][mi.pcm_bit] = pcm2_rx_i;
                end
                if (mi.adp_ok) begin
                    st_d.cap_adp[mi.adp_ch][mi.adp_bit] = adp_rx_i & ~mi.adp_dc;
                end
                if (st_q.pos != '1) st_d.pos = st_q.pos + POS_W'(1);
            end
            if (rise[0]) st_d.opos = st_q.pos;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pcm1_oe_o = win_act & mo.pcm_ok;
    assign pcm2_oe_o = win_act & mo.pcm_ok;
    assign adp_oe_o  = win_act & mo.adp_ok;
    assign pcm1_tx_o = pcm1_oe_o & st_q.tx_pcm[mo.pcm1_ch][mo.pcm_bit];
    assign pcm2_tx_o = pcm2_oe_o & st_q.tx_pcm[mo.pcm2_ch][mo.pcm_bit];
    assign adp_tx_o  = adp_oe_o & ~mo.adp_dc & st_q.tx_adp[mo.adp_ch][mo.adp_bit];

    assign rx_pcm_o = st_q.hold_pcm;
    assign rx_adp_o = st_q.hold_adp;
    assign frame_o  = st_q.frame;
endmodule

// File: rtl/ssi_port_chk.sv
module ssi_port_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        win1_i,
    input logic        win2_i,
    input logic [1:0]  rate_i,
    input logic        sel_i,
    input logic        adp_tx_o,
    input logic        adp_oe_o,
    input logic        pcm1_tx_o,
    input logic        pcm1_oe_o,
    input logic        pcm2_tx_o,
    input logic        pcm2_oe_o,
    input logic [63:0] rx_pcm_o,
    input logic [15:0] rx_adp_o,
    input logic        frame_o
);
    AST_HIZ_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        !(win1_i || win2_i) |-> !(adp_oe_o || pcm1_oe_o || pcm2_oe_o)); // R7

    AST_QUIET_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        !(adp_oe_o && pcm1_oe_o && pcm2_oe_o) |->
            ((adp_oe_o || !adp_tx_o) && (pcm1_oe_o || !pcm1_tx_o) && (pcm2_oe_o || !pcm2_tx_o))); // R7

    AST_NARROW_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        ((rate_i >= 2'd2) && win1_i && !win2_i && sel_i) |-> !adp_oe_o); // R6

    AST_FRAME_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_o |-> ($past(win1_i) && !$past(win1_i, 2))); // R8

    AST_FRAME_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_o |=> !frame_o); // R8

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_o |-> ($stable(rx_pcm_o) && $stable(rx_adp_o))); // R8
endmodule

bind ssi_port ssi_port_chk u_chk (.*);

// File: tb/tb_ssi_port.sv
`timescale 1ns/1ps
module tb_ssi_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bclk = 1'b0, win1 = 1'b0, win2 = 1'b0;
    logic [1:0]  rate = 2'd0;
    logic        lin = 1'b0, sel = 1'b0;
    logic        adp_rx = 1'b0, pcm1_rx = 1'b0, pcm2_rx = 1'b0;
    logic [63:0] pcm_res = '0;
    logic [15:0] adp_res = '0;
    logic        adp_tx, adp_oe, pcm1_tx, pcm1_oe, pcm2_tx, pcm2_oe, frame;
    logic [63:0] rx_pcm;
    logic [15:0] rx_adp;
    int tests = 0, fails = 0;

    always #10 clk = ~clk;

    ssi_port dut (
        .clk(clk), .rst_n(rst_n), .bclk_i(bclk), .win1_i(win1), .win2_i(win2),
        .rate_i(rate), .lin_i(lin), .sel_i(sel), .adp_rx_i(adp_rx),
        .pcm1_rx_i(pcm1_rx), .pcm2_rx_i(pcm2_rx), .pcm_res_i(pcm_res),
        .adp_res_i(adp_res), .adp_tx_o(adp_tx), .adp_oe_o(adp_oe),
        .pcm1_tx_o(pcm1_tx), .pcm1_oe_o(pcm1_oe), .pcm2_tx_o(pcm2_tx),
        .pcm2_oe_o(pcm2_oe), .rx_pcm_o(rx_pcm), .rx_adp_o(rx_adp), .frame_o(frame)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic run_win(input bit w2, input int n, input logic [15:0] p1, input logic [15:0] p2,
                           input logic [7:0] a, output logic [15:0] q1, output logic [15:0] q2,
                           output logic [7:0] qa, output int aoe, output int skew);
        logic [2:0] bv;
        q1 = '0; q2 = '0; qa = '0; aoe = 0; skew = 0;
        @(negedge clk);
        if (w2) win2 = 1'b1; else win1 = 1'b1;
        repeat (2) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            bclk = 1'b1;
            pcm1_rx = p1[n-1-i];
            pcm2_rx = p2[n-1-i];
            adp_rx  = (i < 8) ? a[7-i] : 1'b0;
            repeat (3) @(negedge clk);
            q1[n-1-i] = pcm1_tx;
            q2[n-1-i] = pcm2_tx;
            if (i < 8) qa[7-i] = adp_tx;
            if (adp_oe) aoe++;
            bv = {pcm1_tx, pcm2_tx, adp_tx};
            bclk = 1'b0;
            repeat (2) @(negedge clk);
            pcm1_rx = ~pcm1_rx; pcm2_rx = ~pcm2_rx; adp_rx = ~adp_rx;
            @(negedge clk);
            if ({pcm1_tx, pcm2_tx, adp_tx} != bv) skew++;
        end
        win1 = 1'b0; win2 = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic kick();
        @(negedge clk); win1 = 1'b1;
        @(negedge clk); chk("R8 frame pulse high", 64'(frame), 64'd1);
        @(negedge clk); chk("R8 frame pulse single", 64'(frame), 64'd0);
        win1 = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R10 rx words", {rx_pcm[47:0], rx_adp}, 64'd0);
        chk("R10 serial and flag", 64'({frame, adp_oe, pcm1_oe, pcm2_oe, adp_tx, pcm1_tx, pcm2_tx}), 64'd0);
    endtask

    task automatic t_comp();
        logic [15:0] q1, q2; logic [7:0] qa; int aoe, skew;
        rate = 2'd0; lin = 1'b0;
        pcm_res = {16'h0018, 16'h0024, 16'h0042, 16'h0081};
        adp_res = 16'hD6B2;
        run_win(1'b0, 8, 16'h00A5, 16'h003C, 8'h9E, q1, q2, qa, aoe, skew);
        chk("R2 out pcm1 ch0", 64'(q1[7:0]), 64'h81);
        chk("R2 out pcm2 ch2", 64'(q2[7:0]), 64'h24);
        chk("R4 out adp ch0 ch1", 64'(qa), 64'h2B);
        chk("R7 adp enable count", 64'(aoe), 64'd8);
        chk("R1 output steady after fall", 64'(skew), 64'd0);
        pcm_res = '1; adp_res = 16'h0000;
        run_win(1'b1, 8, 16'h005A, 16'h00C3, 8'h71, q1, q2, qa, aoe, skew);
        chk("R9 out pcm1 ch1", 64'(q1[7:0]), 64'h42);
        chk("R9 out pcm2 ch3", 64'(q2[7:0]), 64'h18);
        chk("R9 out adp ch2 ch3", 64'(qa), 64'h6D);
        kick();
        chk("R2 rx pcm words", rx_pcm, {16'h00C3, 16'h003C, 16'h005A, 16'h00A5});
        chk("R4 rx adp words", 64'(rx_adp), 64'h17E9);
    endtask

    task automatic t_gate();
        logic [15:0] q1, q2; logic [7:0] qa; int aoe, skew, loud;
        rate = 2'd0; lin = 1'b0; loud = 0;
        run_win(1'b0, 8, 16'h0011, 16'h0022, 8'h33, q1, q2, qa, aoe, skew);
        pcm1_rx = 1'b1; pcm2_rx = 1'b1; adp_rx = 1'b1;
        for (int k = 0; k < 10; k++) begin
            bclk = 1'b1; repeat (2) @(negedge clk);
            if (adp_oe || pcm1_oe || pcm2_oe || adp_tx || pcm1_tx || pcm2_tx) loud++;
            bclk = 1'b0; repeat (2) @(negedge clk);
        end
        chk("R7 outputs idle outside windows", 64'(loud), 64'd0);
        repeat (300) @(negedge clk);
        run_win(1'b1, 8, 16'h0044, 16'h0055, 8'h66, q1, q2, qa, aoe, skew);
        kick();
        chk("R11 rx pcm after gap", rx_pcm, {16'h0055, 16'h0022, 16'h0044, 16'h0011});
        chk("R11 rx adp after gap", 64'(rx_adp), 64'h6633);
        kick();
        chk("R8 unwritten channels zero", {rx_pcm[47:0], rx_adp}, 64'd0);
    endtask

    task automatic t_24();
        logic [15:0] q1, q2; logic [7:0] qa; int aoe, skew;
        rate = 2'd1; lin = 1'b0; adp_res = 16'hFFFF;
        run_win(1'b0, 8, 16'h0000, 16'h0000, 8'hFF, q1, q2, qa, aoe, skew);
        chk("R5 out fourth bit low w1", 64'(qa), 64'hEE);
        run_win(1'b1, 8, 16'h0000, 16'h0000, 8'hFF, q1, q2, qa, aoe, skew);
        chk("R5 out fourth bit low w2", 64'(qa), 64'hEE);
        kick();
        chk("R5 rx fourth bit ignored", 64'(rx_adp), 64'hEEEE);
    endtask

    task automatic t_16();
        logic [15:0] q1, q2; logic [7:0] qa; int aoe, skew;
        rate = 2'd2; lin = 1'b0; sel = 1'b0; adp_res = 16'h4C08;
        run_win(1'b0, 8, 16'h0000, 16'h0000, 8'hB4, q1, q2, qa, aoe, skew);
        chk("R6 out packed octet sel0", 64'(qa), 64'h8D);
        chk("R6 enable in chosen window", 64'(aoe), 64'd8);
        run_win(1'b1, 8, 16'h0000, 16'h0000, 8'hFF, q1, q2, qa, aoe, skew);
        chk("R6 idle in other window", 64'(aoe), 64'd0);
        kick();
        chk("R6 rx packed sel0", 64'(rx_adp), 64'h04C8);
        sel = 1'b1;
        run_win(1'b0, 8, 16'h0000, 16'h0000, 8'hFF, q1, q2, qa, aoe, skew);
        chk("R6 idle in window one sel1", 64'(aoe), 64'd0);
        run_win(1'b1, 8, 16'h0000, 16'h0000, 8'h1B, q1, q2, qa, aoe, skew);
        chk("R6 out packed octet sel1", 64'(qa), 64'h8D);
        kick();
        chk("R6 rx packed sel1", 64'(rx_adp), 64'hC840);
        sel = 1'b0;
    endtask

    task automatic t_lin();
        logic [15:0] q1, q2; logic [7:0] qa; int aoe, skew;
        rate = 2'd0; lin = 1'b1;
        pcm_res = {16'h8001, 16'h7FFE, 16'h1234, 16'hCDEF};
        run_win(1'b0, 16, 16'hF123, 16'h0ABC, 8'h00, q1, q2, qa, aoe, skew);
        chk("R3 out linear ch0", 64'(q1), 64'hCDEF);
        chk("R3 out linear ch2", 64'(q2), 64'h7FFE);
        chk("R7 adp drives eight of sixteen", 64'(aoe), 64'd8);
        chk("R1 linear output steady", 64'(skew), 64'd0);
        run_win(1'b1, 16, 16'h1FFF, 16'hE000, 8'h00, q1, q2, qa, aoe, skew);
        chk("R3 out linear ch1", 64'(q1), 64'h1234);
        chk("R3 out linear ch3", 64'(q2), 64'h8001);
        kick();
        chk("R3 rx linear words", rx_pcm, {16'hE000, 16'h0ABC, 16'h1FFF, 16'hF123});
        lin = 1'b0;
    endtask

    initial begin
        #3_000_000;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_comp();
        t_gate();
        t_24();
        t_16();
        t_lin();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule